// File: doc/BRIEF.md
# Floating-Point Compare and Classify Unit

A purely combinational unit that evaluates one of two predicate-producing operations on 82-bit register-format floating-point values (1 sign bit, 17-bit exponent with bias 0xFFFF, 64-bit significand with an explicit integer bit in its top bit). The compare operation tests a relation between two operands. The classify operation tests whether one operand belongs to a set of categories chosen by a 9-bit mask. Either way the outcome drives a pair of predicate values. The first predicate gets the outcome and the second gets its complement.

The unit also generates write enables for the two predicates from a qualifying predicate and an unconditional mode. With the qualifier true, both predicates are written normally. With the qualifier false and the unconditional mode off, nothing is written. With the qualifier false and the unconditional mode on, both predicates are written as zero. Magnitude comparison first normalises unnormalised significands, so redundant encodings of the same value compare by value.

Top module: `fpcc_unit`

## Requirements
- R1: With `op_sel`=0, `rel_sel` selects the relation: 0 equal, 1 less, 2 less-or-equal, 3 greater, 4 greater-or-equal, 5 unordered. Ordered operands (including infinities) are compared by signed value, with no unsigned variant.
- R2: An operand that is a quiet NaN, a signaling NaN, an unsupported encoding (exponent all ones with integer bit 0) or NaTVal makes relations 0 to 4 false, including equality of a NaN with itself, and makes relation 5 true. Relation 5 is false for two ordered operands.
- R3: Every zero encoding compares equal to every other, whatever its sign. This covers true zeros and pseudo-zeros (significand 0, exponent neither 0x1FFFF nor, with positive sign, 0x1FFFE). NaTVal is not equal to zero.
- R4: Unnormalised operands compare by value. Exponent 0 acts as exponent 1, and the significand is shifted left to its leading one with the exponent reduced to match.
- R5: When the qualifier `qp` is 1, `p1` carries the outcome and `p2` its complement. Relation codes 6 and 7 give an outcome of 0.
- R6: With `qp`=0 and `unc`=0, both write enables are 0 and both predicate values are 0.
- R7: With `qp`=0 and `unc`=1, both write enables are 1 and both predicate values are 0. With `qp`=1, `unc` has no effect.
- R8: Classification assigns each operand exactly one category, by mask bit. Bit 2 zero: significand 0, not NaTVal, exponent not all ones. Bit 3 unnormalised: integer bit 0, significand nonzero, exponent not all ones. Bit 4 normalised: integer bit 1, exponent not all ones. Bit 5 infinity: exponent all ones, integer bit 1, remaining bits 0. Bit 7 quiet NaN: exponent all ones, top two significand bits 1. Bit 6 signaling NaN: every other all-ones-exponent encoding. Bit 8 NaTVal.
- R9: With `op_sel`=1, an operand is a member when it matches a selected sign bit (bit 0 positive, bit 1 negative) together with a selected bit among 2 to 5, or when it matches a selected bit among 6 to 8.
- R10: `cls_not`=0 sends membership as the outcome; `cls_not`=1 sends its inverse.
- R11: NaTVal (sign 0, exponent 0x1FFFE, significand 0) matches only bit 8. It never matches the zero bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 1 | 0 compare, 1 classify |
| rel_sel | input | 3 | Relation code for compare |
| cls_not | input | 1 | Classify sense: 0 member, 1 not member |
| cls_mask | input | 9 | Category selection mask for classify |
| opnd_a | input | 82 | First operand (classified operand) |
| opnd_b | input | 82 | Second operand (compare only) |
| qp | input | 1 | Qualifying predicate |
| unc | input | 1 | Unconditional mode |
| p1 | output | 1 | First predicate value |
| p2 | output | 1 | Second predicate value |
| p1_we | output | 1 | Write enable for first predicate |
| p2_we | output | 1 | Write enable for second predicate |

## Verification
The bench builds the unit with its default widths: a 17-bit exponent and a 64-bit significand. At these widths the exact encodings that matter can be reached. These are NaTVal at exponent 0x1FFFE, pseudo-zeros, pseudo-NaNs with integer bit 0, and unnormals whose value equals a normal one. The vector table pairs these against ordinary values under every relation code and many mask combinations. Directed steps cover the idle state and the qualifier/unconditional combinations.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int EXP_W_DEF = 17;
  localparam int SIG_W_DEF = 64;

  typedef enum logic {
    OP_CMP   = 1'b0,
    OP_CLASS = 1'b1
  } fpcc_op_e;

  typedef enum logic [2:0] {
    REL_EQ    = 3'd0,
    REL_LT    = 3'd1,
    REL_LE    = 3'd2,
    REL_GT    = 3'd3,
    REL_GE    = 3'd4,
    REL_UNORD = 3'd5
  } fpcc_rel_e;

  // category bit positions in the classify mask
  localparam int CM_POS   = 0;
  localparam int CM_NEG   = 1;
  localparam int CM_ZERO  = 2;
  localparam int CM_UNORM = 3;
  localparam int CM_NORM  = 4;
  localparam int CM_INF   = 5;
  localparam int CM_SNAN  = 6;
  localparam int CM_QNAN  = 7;
  localparam int CM_NATV  = 8;
  localparam int CM_W     = 9;

  typedef struct packed {
    logic sgn;
    logic zero;
    logic unnorm;
    logic norm;
    logic inf;
    logic snan;
    logic qnan;
    logic natval;
  } fp_cat_t;

endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
  import fpcc_pkg::*;
#(
  parameter int EXP_W = EXP_W_DEF,
  parameter int SIG_W = SIG_W_DEF
) (
  input  logic [EXP_W+SIG_W:0]      val,
  output fp_cat_t                   cat,
  output logic signed [EXP_W+1:0]   nexp,
  output logic [SIG_W-1:0]          nsig
);

  localparam int LZ_W = $clog2(SIG_W + 1);
  localparam logic [EXP_W-1:0] EXP_ALL1 = '1;
  localparam logic [EXP_W-1:0] EXP_NATV = EXP_ALL1 - 1'b1;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [SIG_W-1:0] sig;
  logic             ex_max, int_bit, sig_zero, frac_zero;
  logic [EXP_W-1:0] ex_eff;
  logic [LZ_W-1:0]  lzc;

  assign sgn       = val[EXP_W+SIG_W];
  assign ex        = val[EXP_W+SIG_W-1:SIG_W];
  assign sig       = val[SIG_W-1:0];
  assign ex_max    = (ex == EXP_ALL1);
  assign int_bit   = sig[SIG_W-1];
  assign sig_zero  = (sig == '0);
  assign frac_zero = (sig[SIG_W-2:0] == '0);

  always_comb begin
    cat.sgn    = sgn;
    cat.natval = ~sgn & (ex == EXP_NATV) & sig_zero;
    cat.zero   = sig_zero & ~ex_max & ~cat.natval;
    cat.unnorm = ~int_bit & ~sig_zero & ~ex_max;
    cat.norm   = int_bit & ~ex_max;
    cat.inf    = ex_max & int_bit & frac_zero;
    cat.qnan   = ex_max & int_bit & sig[SIG_W-2];
    cat.snan   = ex_max & ~(int_bit & frac_zero) & ~(int_bit & sig[SIG_W-2]);
  end

  // leading-zero count: the highest set bit wins
  always_comb begin
    lzc = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (sig[i]) lzc = LZ_W'(SIG_W - 1 - i);
    end
  end

  assign ex_eff = (ex == '0) ? EXP_W'(1) : ex;
  assign nexp   = $signed({2'b00, ex_eff}) - $signed({{(EXP_W+2-LZ_W){1'b0}}, lzc});
  assign nsig   = sig << lzc;

  always_comb begin
    if (!$isunknown(val)) begin
      assert_one_category_R8: assert ($onehot({cat.zero, cat.unnorm, cat.norm, cat.inf,
                                               cat.snan, cat.qnan, cat.natval}))
        else $error("operand maps to other than one category");
      assert_norm_lead_R4: assert (sig_zero || nsig[SIG_W-1])
        else $error("normalised significand lacks leading one");
    end
  end

endmodule

// File: rtl/fpcc_compare.sv
module fpcc_compare
  import fpcc_pkg::*;
#(
  parameter int EXP_W = EXP_W_DEF,
  parameter int SIG_W = SIG_W_DEF
) (
  input  fp_cat_t                 cat_a,
  input  fp_cat_t                 cat_b,
  input  logic signed [EXP_W+1:0] nexp_a,
  input  logic signed [EXP_W+1:0] nexp_b,
  input  logic [SIG_W-1:0]        nsig_a,
  input  logic [SIG_W-1:0]        nsig_b,
  input  logic [2:0]              rel,
  output logic                    hit
);

  logic unord, mag_lt, mag_eq, o_lt, o_eq, o_gt;

  assign unord = cat_a.snan | cat_a.qnan | cat_a.natval |
                 cat_b.snan | cat_b.qnan | cat_b.natval;

  assign mag_eq = (nexp_a == nexp_b) && (nsig_a == nsig_b);
  assign mag_lt = (nexp_a < nexp_b) || ((nexp_a == nexp_b) && (nsig_a < nsig_b));

  always_comb begin
    o_lt = 1'b0;
    o_eq = 1'b0;
    if (cat_a.zero && cat_b.zero) begin
      o_eq = 1'b1;
    end else if (cat_a.zero) begin
      o_lt = ~cat_b.sgn;
    end else if (cat_b.zero) begin
      o_lt = cat_a.sgn;
    end else if (cat_a.sgn != cat_b.sgn) begin
      o_lt = cat_a.sgn;
    end else begin
      o_eq = mag_eq;
      o_lt = cat_a.sgn ? (~mag_lt & ~mag_eq) : mag_lt;
    end
    o_gt = ~o_lt & ~o_eq;
  end

  always_comb begin
    unique case (rel)
      REL_EQ:    hit = ~unord & o_eq;
      REL_LT:    hit = ~unord & o_lt;
      REL_LE:    hit = ~unord & (o_lt | o_eq);
      REL_GT:    hit = ~unord & o_gt;
      REL_GE:    hit = ~unord & (o_gt | o_eq);
      REL_UNORD: hit = unord;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({cat_a, cat_b, nexp_a, nexp_b, nsig_a, nsig_b, rel})) begin
      assert_trichotomy_R1: assert (unord || $onehot({o_lt, o_eq, o_gt}))
        else $error("ordered outcome not exclusive");
      assert_zero_eq_R3: assert (!(cat_a.zero && cat_b.zero && rel == REL_EQ) || hit)
        else $error("two zeros not equal");
      assert_nan_false_R2: assert (!(unord && rel != REL_UNORD) || !hit)
        else $error("ordered relation true on unordered pair");
    end
  end

endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify
  import fpcc_pkg::*;
(
  input  fp_cat_t          cat,
  input  logic [CM_W-1:0]  mask,
  output logic             member
);

  logic sign_hit, class_hit, special_hit;

  assign sign_hit    = (mask[CM_POS] & ~cat.sgn) | (mask[CM_NEG] & cat.sgn);
  assign class_hit   = (mask[CM_ZERO]  & cat.zero)   |
                       (mask[CM_UNORM] & cat.unnorm) |
                       (mask[CM_NORM]  & cat.norm)   |
                       (mask[CM_INF]   & cat.inf);
  assign special_hit = (mask[CM_SNAN] & cat.snan) |
                       (mask[CM_QNAN] & cat.qnan) |
                       (mask[CM_NATV] & cat.natval);
  assign member      = (sign_hit & class_hit) | special_hit;

  always_comb begin
    if (!$isunknown({cat, mask})) begin
      assert_natval_only_R11: assert (!cat.natval || member == mask[CM_NATV])
        else $error("NaTVal matched a bit other than its own");
      assert_empty_mask_R9: assert (mask != '0 || !member)
        else $error("empty mask produced membership");
    end
  end

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int EXP_W = EXP_W_DEF,
  parameter int SIG_W = SIG_W_DEF
) (
  input  logic                   op_sel,
  input  logic [2:0]             rel_sel,
  input  logic                   cls_not,
  input  logic [CM_W-1:0]        cls_mask,
  input  logic [EXP_W+SIG_W:0]   opnd_a,
  input  logic [EXP_W+SIG_W:0]   opnd_b,
  input  logic                   qp,
  input  logic                   unc,
  output logic                   p1,
  output logic                   p2,
  output logic                   p1_we,
  output logic                   p2_we
);

  localparam int N_OPND = 2;
  localparam int VAL_W  = EXP_W + SIG_W + 1;

  logic [VAL_W-1:0]        opnd   [N_OPND];
  fp_cat_t                 cat    [N_OPND];
  logic signed [EXP_W+1:0] nexp   [N_OPND];
  logic [SIG_W-1:0]        nsig   [N_OPND];

  logic cmp_hit, member, outcome;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_dec
    fpcc_decode #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_dec (
      .val  (opnd[g]),
      .cat  (cat[g]),
      .nexp (nexp[g]),
      .nsig (nsig[g])
    );
  end

  fpcc_compare #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_cmp (
    .cat_a  (cat[0]),
    .cat_b  (cat[1]),
    .nexp_a (nexp[0]),
    .nexp_b (nexp[1]),
    .nsig_a (nsig[0]),
    .nsig_b (nsig[1]),
    .rel    (rel_sel),
    .hit    (cmp_hit)
  );

  fpcc_classify i_cls (
    .cat    (cat[0]),
    .mask   (cls_mask),
    .member (member)
  );

  assign outcome = (fpcc_op_e'(op_sel) == OP_CLASS) ? (member ^ cls_not) : cmp_hit;

  always_comb begin
    p1    = qp & outcome;
    p2    = qp & ~outcome;
    p1_we = qp | unc;
    p2_we = qp | unc;
  end

  always_comb begin
    if (!$isunknown({op_sel, rel_sel, cls_not, cls_mask, opnd_a, opnd_b, qp, unc})) begin
      assert_pair_complement_R5: assert (!qp || (p1 != p2))
        else $error("predicates not complementary");
      assert_cleared_values_R7: assert (qp || (!p1 && !p2))
        else $error("predicate value set without qualifier");
      assert_no_write_R6: assert (qp || unc || (!p1_we && !p2_we))
        else $error("write enabled with qualifier and unc both low");
    end
  end

endmodule

// File: tb/test_fpcc_unit.sv
module test_fpcc_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W = 82;

  localparam logic [W-1:0] P1V   = {1'b0, 17'h0FFFF, 64'h8000_0000_0000_0000};
  localparam logic [W-1:0] N1V   = {1'b1, 17'h0FFFF, 64'h8000_0000_0000_0000};
  localparam logic [W-1:0] P2V   = {1'b0, 17'h10000, 64'h8000_0000_0000_0000};
  localparam logic [W-1:0] PZ    = {1'b0, 17'h00000, 64'h0};
  localparam logic [W-1:0] NZ    = {1'b1, 17'h00000, 64'h0};
  localparam logic [W-1:0] PSZ   = {1'b0, 17'h00123, 64'h0};
  localparam logic [W-1:0] UN1   = {1'b0, 17'h10000, 64'h4000_0000_0000_0000};
  localparam logic [W-1:0] DEN   = {1'b0, 17'h00000, 64'h0000_0000_0000_0001};
  localparam logic [W-1:0] PINF  = {1'b0, 17'h1FFFF, 64'h8000_0000_0000_0000};
  localparam logic [W-1:0] NINF  = {1'b1, 17'h1FFFF, 64'h8000_0000_0000_0000};
  localparam logic [W-1:0] QNAN  = {1'b0, 17'h1FFFF, 64'hC000_0000_0000_0000};
  localparam logic [W-1:0] SNAN  = {1'b0, 17'h1FFFF, 64'hA000_0000_0000_0000};
  localparam logic [W-1:0] PSNAN = {1'b0, 17'h1FFFF, 64'h4000_0000_0000_0000};
  localparam logic [W-1:0] NATV  = {1'b0, 17'h1FFFE, 64'h0};

  localparam logic [2:0] EQ = 3'd0, LT = 3'd1, LE = 3'd2, GT = 3'd3, GE = 3'd4, UN = 3'd5;

  typedef struct packed {
    logic         op;
    logic [2:0]   rel;
    logic         neg;
    logic [8:0]   mask;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         qp;
    logic         unc;
    logic         e_p1;
    logic         e_p2;
    logic         e_we1;
    logic         e_we2;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VT [NV] = '{
    // R1 ordered relations
    '{1'b0, EQ, 1'b0, 9'h000, P1V,  P1V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b0, LT, 1'b0, 9'h000, P1V,  P2V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b0, LE, 1'b0, 9'h000, P2V,  P1V,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd1},
    '{1'b0, GT, 1'b0, 9'h000, P1V,  N1V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b0, GE, 1'b0, 9'h000, N1V,  P1V,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd1},
    '{1'b0, LT, 1'b0, 9'h000, NINF, N1V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b0, GT, 1'b0, 9'h000, PINF, P2V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b0, LT, 1'b0, 9'h000, N1V,  PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b0, GE, 1'b0, 9'h000, P2V,  P2V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b0, LE, 1'b0, 9'h000, N1V,  NINF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd1},
    // R2 unordered operands
    '{1'b0, EQ, 1'b0, 9'h000, QNAN, QNAN, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd2},
    '{1'b0, UN, 1'b0, 9'h000, QNAN, P1V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2},
    '{1'b0, LE, 1'b0, 9'h000, SNAN, P1V,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd2},
    '{1'b0, UN, 1'b0, 9'h000, P1V,  NATV, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2},
    '{1'b0, UN, 1'b0, 9'h000, PSNAN,P1V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2},
    '{1'b0, UN, 1'b0, 9'h000, P1V,  P2V,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd2},
    // R3 zero encodings
    '{1'b0, EQ, 1'b0, 9'h000, PZ,   NZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd3},
    '{1'b0, EQ, 1'b0, 9'h000, PSZ,  NZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd3},
    '{1'b0, LT, 1'b0, 9'h000, NZ,   PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd3},
    '{1'b0, EQ, 1'b0, 9'h000, NATV, PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd3},
    // R4 unnormalised values
    '{1'b0, EQ, 1'b0, 9'h000, UN1,  P1V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd4},
    '{1'b0, LT, 1'b0, 9'h000, DEN,  P1V,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd4},
    '{1'b0, GT, 1'b0, 9'h000, DEN,  PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd4},
    '{1'b0, GT, 1'b0, 9'h000, P2V,  UN1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd4},
    // R5 unused relation codes
    '{1'b0, 3'd6, 1'b0, 9'h000, P1V, P1V, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd5},
    '{1'b0, 3'd7, 1'b0, 9'h000, QNAN,P1V, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd5},
    // R8 R9 R11 classification
    '{1'b1, EQ, 1'b0, 9'h011, P1V,  PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd9},
    '{1'b1, EQ, 1'b0, 9'h011, N1V,  PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd9},
    '{1'b1, EQ, 1'b0, 9'h011, UN1,  PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8},
    '{1'b1, EQ, 1'b0, 9'h009, UN1,  PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd8},
    '{1'b1, EQ, 1'b0, 9'h005, PSZ,  PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd8},
    '{1'b1, EQ, 1'b0, 9'h009, DEN,  PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd8},
    '{1'b1, EQ, 1'b0, 9'h100, NATV, PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd11},
    '{1'b1, EQ, 1'b0, 9'h007, NATV, PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd11},
    '{1'b1, EQ, 1'b0, 9'h080, QNAN, PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd8},
    '{1'b1, EQ, 1'b0, 9'h040, QNAN, PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8},
    '{1'b1, EQ, 1'b0, 9'h040, PSNAN,PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd8},
    '{1'b1, EQ, 1'b0, 9'h023, NINF, PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd9},
    '{1'b1, EQ, 1'b0, 9'h003, P1V,  PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd9},
    // R10 inverted sense
    '{1'b1, EQ, 1'b1, 9'h011, P1V,  PZ,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd10},
    '{1'b1, EQ, 1'b1, 9'h080, P1V,  PZ,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd10},
    // R6 qualifier false, no writes
    '{1'b0, EQ, 1'b0, 9'h000, P1V,  P1V,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{1'b1, EQ, 1'b0, 9'h011, P1V,  PZ,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    // R7 unconditional clearing
    '{1'b0, EQ, 1'b0, 9'h000, P1V,  P1V,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd7},
    '{1'b1, EQ, 1'b1, 9'h000, P1V,  PZ,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd7},
    '{1'b0, LT, 1'b0, 9'h000, P1V,  P2V,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd7}
  };

  logic         clk = 1'b0;
  logic         op_sel, cls_not, qp, unc;
  logic [2:0]   rel_sel;
  logic [8:0]   cls_mask;
  logic [W-1:0] opnd_a, opnd_b;
  logic         p1, p2, p1_we, p2_we;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcc_unit i_fpcc_unit (
    .op_sel   (op_sel),
    .rel_sel  (rel_sel),
    .cls_not  (cls_not),
    .cls_mask (cls_mask),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .qp       (qp),
    .unc      (unc),
    .p1       (p1),
    .p2       (p2),
    .p1_we    (p1_we),
    .p2_we    (p2_we)
  );

  task automatic check(input logic [3:0] exp_v, input int req, input int idx);
    total++;
    if ({p1, p2, p1_we, p2_we} !== exp_v) begin
      bad++;
      $display("FAIL step %0d R%0d: got p1,p2,we1,we2=%b expected %b",
               idx, req, {p1, p2, p1_we, p2_we}, exp_v);
    end
  endtask

  initial begin
    // idle inputs: qualifier and unc low (R6 reset state)
    op_sel = 1'b0; rel_sel = EQ; cls_not = 1'b0; cls_mask = '0;
    opnd_a = PZ; opnd_b = PZ; qp = 1'b0; unc = 1'b0;
    @(negedge clk);
    check(4'b0000, 6, -1);

    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      op_sel   = VT[k].op;
      rel_sel  = VT[k].rel;
      cls_not  = VT[k].neg;
      cls_mask = VT[k].mask;
      opnd_a   = VT[k].a;
      opnd_b   = VT[k].b;
      qp       = VT[k].qp;
      unc      = VT[k].unc;
      @(negedge clk);
      check({VT[k].e_p1, VT[k].e_p2, VT[k].e_we1, VT[k].e_we2}, int'(VT[k].req), k);
    end

    // directed: R7 qualifier drops mid-stream with unc set clears a true outcome
    @(posedge clk);
    op_sel = 1'b0; rel_sel = GE; opnd_a = PINF; opnd_b = NINF; qp = 1'b1; unc = 1'b1;
    @(negedge clk);
    check(4'b1011, 7, 100);
    @(posedge clk);
    qp = 1'b0;
    @(negedge clk);
    check(4'b0011, 7, 101);
    // directed: R6 changing operands while idle keeps writes off
    @(posedge clk);
    unc = 1'b0; opnd_a = QNAN; rel_sel = UN;
    @(negedge clk);
    check(4'b0000, 6, 102);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule